// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block walks a dual-role USB 3.0 PHY wrapper through its bring-up and shutdown. It holds its own copy of every control register the wrapper needs and presents each copy as an output bus. A host-side controller pulses `req_valid` with an operation code. The block then performs a fixed series of register updates, one per clock. It reports the end of the series with a single-cycle `done`.

Bring-up depends on two values taken when the request is accepted. The path select chooses the high-speed UTMI path or the SuperSpeed PIPE3 path. The 3-bit reference-frequency code feeds the clock/reset register. Bring-up ends with a port-reset pulse of a fixed duration. That duration is counted in clock cycles and derived from the clock-frequency and pulse-length parameters. Shutdown puts the UTMI side to sleep, turns off the reference, spread-spectrum and common-block enables, and powers down both analog halves to cut leakage.

States: `ST_IDLE` waits for a request. Bring-up runs `ST_CLR_CR` → `ST_CLR_RES` → `ST_LINK` → `ST_PAD_OFF` → `ST_CLKSEL`. The UTMI path then goes through `ST_LOS` and the PIPE3 path skips it. Both paths go to `ST_DEEMPH`. The UTMI path then goes through `ST_OTG` and the PIPE3 path skips it. The series continues `ST_TEST_ON` → `ST_CLK_ON` → `ST_RST_WAIT`, which stays until the timer expires. It ends `ST_RST_REL` → `ST_DONE` → `ST_IDLE`. Shutdown runs `ST_SLEEP` → `ST_CLK_OFF` → `ST_TEST_OFF` → `ST_DONE` → `ST_IDLE`.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After reset:
  - `busy`, `done` and `wr_stb` are 0.
  - `img_test` is 0x0000000C and `img_param0` is 0x80000000.
  - Every other image is zero.
- R2: A request is taken only in idle, when `req_valid`=1. `req_op`=0 selects bring-up and 1 selects shutdown. `mode_pipe`=0 selects UTMI and 1 selects PIPE3. Path and frequency code are latched at acceptance. Requests and input changes while `busy`=1 have no effect on the writes, the images or the latency.
- R3: Bring-up starts with five writes in this order, shown as `wr_sel` (target: action):
  - 0 (control-port register): clear to zero.
  - 1 (resume register): clear to zero.
  - 2 (link register): write 0x08000040, which sets bit 27 and puts 0x20 in bits [6:1].
  - 3 (parameter register 0): clear bit 31.
  - 8 (clock-select register): set bit 2.
- R4: On the UTMI path, these writes follow in order:
  - `wr_sel` 3: put 0x9 in bits [30:26].
  - `wr_sel` 4: put 0x1C in bits [4:0].
  - `wr_sel` 5: write exactly 0x00000040.
  - `wr_sel` 6: clear bit 2.
- R5: On the PIPE3 path, these writes follow in order:
  - `wr_sel` 4: put 0x1C in bits [4:0].
  - `wr_sel` 6: clear bit 3.
  - Bit 2 of `img_test` and all of `img_utmi` are left as they were.
- R6: The bring-up write to the clock/reset image (`wr_sel` 7) changes these fields:
  - Clears fields [30:23], [17:11], [7:5] and [3:2].
  - Sets [3:2]=3.
  - Sets bits 0, 1, 4, 19 and 20.
  - On the UTMI path, places the frequency code in [7:5].
- R7: On the PIPE3 path, the frequency code selects [17:11] and [30:23] as follows:
  - Code 7: 0x32 and 0x00.
  - Code 5: 0x68 and 0x88.
  - Code 4: 0x7D and 0x00.
  - Code 3: 0x02 and 0x88.
  - Any other code: both fields 0.
- R8: Bit 1 of `img_clkrst` stays high for exactly `RST_CYCLES` = `CLK_HZ`/1e6 × `RST_US` cycles. It is then cleared by a second write to `wr_sel` 7 that changes no other bit.
- R9: Shutdown writes in this order:
  - `wr_sel` 5: write 0x00000043.
  - `wr_sel` 7: clear bits 0, 19 and 20.
  - `wr_sel` 6: set bits 2 and 3.
- R10: `done` is high for one cycle, and `busy` is low in the cycle after it. Measured from the cycle after the accepting edge, `done` falls in the following cycle:
  - UTMI bring-up: cycle 11+`RST_CYCLES`.
  - PIPE3 bring-up: cycle 9+`RST_CYCLES`.
  - Shutdown: cycle 4.
- R11: `wr_stb` marks each write, and `wr_sel` names its target. No image changes in a cycle without `wr_stb`, and `wr_stb` is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse |
| req_op | input | 1 | 0 bring-up, 1 shutdown |
| mode_pipe | input | 1 | 0 UTMI path, 1 PIPE3 path |
| freq_code | input | 3 | Reference-frequency code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_stb | output | 1 | A register write happens this cycle |
| wr_sel | output | 4 | Target of the current write |
| img_crctl | output | 32 | Control-port register image |
| img_resume | output | 32 | Resume register image |
| img_link | output | 32 | Link register image |
| img_param0 | output | 32 | Parameter register 0 image |
| img_param1 | output | 32 | Parameter register 1 image |
| img_utmi | output | 32 | UTMI control image |
| img_test | output | 32 | Power-down/test image |
| img_clkrst | output | 32 | Clock/reset image |
| img_clksel | output | 32 | Clock-select image |

## Verification
Each write shows `wr_stb` and `wr_sel` in the cycle before the edge that updates its image. The new image value is therefore first visible one sample after the strobe. `done` is sampled at the cycle counts given in R10, counting negedge samples from the cycle that follows the accepting edge. The port-reset width is counted as the number of samples with bit 1 high. All image comparisons wait until after `done`, when every write has landed. The idle checks sample one and two cycles later still, to confirm that a request made during the run left no trace.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE, ST_CLR_CR, ST_CLR_RES, ST_LINK, ST_PAD_OFF, ST_CLKSEL,
        ST_LOS, ST_DEEMPH, ST_OTG, ST_TEST_ON, ST_CLK_ON, ST_RST_WAIT,
        ST_RST_REL, ST_SLEEP, ST_CLK_OFF, ST_TEST_OFF, ST_DONE
    } state_e;

    typedef enum logic [3:0] {
        ACT_NONE, ACT_CLR_CR, ACT_CLR_RES, ACT_LINK, ACT_PAD_OFF, ACT_CLKSEL,
        ACT_LOS, ACT_DEEMPH, ACT_OTG, ACT_HS_UP, ACT_SS_UP, ACT_CLK_ON,
        ACT_CLK_REL, ACT_SLEEP, ACT_CLK_OFF, ACT_PWR_OFF
    } act_e;

    localparam int SEL_W = 4;

    // register targets reported on wr_sel
    localparam logic [SEL_W-1:0] TGT_CRCTL  = 4'd0;
    localparam logic [SEL_W-1:0] TGT_RESUME = 4'd1;
    localparam logic [SEL_W-1:0] TGT_LINK   = 4'd2;
    localparam logic [SEL_W-1:0] TGT_PARAM0 = 4'd3;
    localparam logic [SEL_W-1:0] TGT_PARAM1 = 4'd4;
    localparam logic [SEL_W-1:0] TGT_UTMI   = 4'd5;
    localparam logic [SEL_W-1:0] TGT_TEST   = 4'd6;
    localparam logic [SEL_W-1:0] TGT_CLKRST = 4'd7;
    localparam logic [SEL_W-1:0] TGT_CLKSEL = 4'd8;

    // field constants
    localparam logic [31:0] LINK_INIT     = 32'h0800_0040;
    localparam logic [31:0] P0_PAD_BIT    = 32'h8000_0000;
    localparam logic [31:0] P0_LOS_MASK   = 32'h7C00_0000;
    localparam logic [31:0] P0_LOS_VAL    = 32'h2400_0000;
    localparam logic [31:0] P1_DE_MASK    = 32'h0000_001F;
    localparam logic [31:0] P1_DE_VAL     = 32'h0000_001C;
    localparam logic [31:0] UTMI_RUN      = 32'h0000_0040;
    localparam logic [31:0] UTMI_SLEEP    = 32'h0000_0043;
    localparam logic [31:0] TEST_HS_PD    = 32'h0000_0004;
    localparam logic [31:0] TEST_SS_PD    = 32'h0000_0008;
    localparam logic [31:0] CLKSEL_BIT    = 32'h0000_0004;
    localparam logic [31:0] CK_FIELD_MASK = 32'h7F83_F8EC;
    localparam logic [31:0] CK_EXT_REF    = 32'h0000_000C;
    localparam logic [31:0] CK_ENABLES    = 32'h0018_0011;
    localparam logic [31:0] CK_OFF_MASK   = 32'h0018_0001;
    localparam logic [31:0] CK_PORT_RST   = 32'h0000_0002;

    localparam logic [31:0] TEST_RST_VAL  = 32'h0000_000C;
    localparam logic [31:0] P0_RST_VAL    = 32'h8000_0000;

    function automatic logic [SEL_W-1:0] act_target(act_e a);
        logic [SEL_W-1:0] t;
        unique case (a)
            ACT_CLR_CR:                          t = TGT_CRCTL;
            ACT_CLR_RES:                         t = TGT_RESUME;
            ACT_LINK:                            t = TGT_LINK;
            ACT_PAD_OFF, ACT_LOS:                t = TGT_PARAM0;
            ACT_DEEMPH:                          t = TGT_PARAM1;
            ACT_OTG, ACT_SLEEP:                  t = TGT_UTMI;
            ACT_HS_UP, ACT_SS_UP, ACT_PWR_OFF:   t = TGT_TEST;
            ACT_CLK_ON, ACT_CLK_REL, ACT_CLK_OFF: t = TGT_CLKRST;
            ACT_CLKSEL:                          t = TGT_CLKSEL;
            default:                             t = '0;
        endcase
        return t;
    endfunction

    // multiplier [17:11] and spread-spectrum reference [30:23] per code
    function automatic logic [31:0] pll_fields(logic [2:0] code);
        logic [6:0] mul;
        logic [7:0] ssc;
        unique case (code)
            3'd7:    begin mul = 7'h32; ssc = 8'h00; end
            3'd5:    begin mul = 7'h68; ssc = 8'h88; end
            3'd4:    begin mul = 7'h7D; ssc = 8'h00; end
            3'd3:    begin mul = 7'h02; ssc = 8'h88; end
            default: begin mul = 7'h00; ssc = 8'h00; end
        endcase
        return {1'b0, ssc, 5'b0, mul, 11'b0};
    endfunction

endpackage

// File: rtl/usbphy_seq_timer.sv
module usbphy_seq_timer #(
    parameter int unsigned LOAD = 2498
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int W = (LOAD < 1) ? 1 : $clog2(LOAD + 1);
    localparam logic [W-1:0] LOAD_V = W'(LOAD);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/usbphy_seq_fsm.sv
module usbphy_seq_fsm
    import usbphy_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_op,
    input  logic       mode_pipe,
    input  logic [2:0] freq_code,
    input  logic       tmr_expired,
    output act_e       act,
    output logic       mode_q,
    output logic [2:0] freq_q,
    output logic       tmr_start,
    output logic       busy,
    output logic       done
);
    state_e state_q, state_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = req_op ? ST_SLEEP : ST_CLR_CR;
            ST_CLR_CR:   state_d = ST_CLR_RES;
            ST_CLR_RES:  state_d = ST_LINK;
            ST_LINK:     state_d = ST_PAD_OFF;
            ST_PAD_OFF:  state_d = ST_CLKSEL;
            ST_CLKSEL:   state_d = mode_q ? ST_DEEMPH : ST_LOS;
            ST_LOS:      state_d = ST_DEEMPH;
            ST_DEEMPH:   state_d = mode_q ? ST_TEST_ON : ST_OTG;
            ST_OTG:      state_d = ST_TEST_ON;
            ST_TEST_ON:  state_d = ST_CLK_ON;
            ST_CLK_ON:   state_d = ST_RST_WAIT;
            ST_RST_WAIT: if (tmr_expired) state_d = ST_RST_REL;
            ST_RST_REL:  state_d = ST_DONE;
            ST_SLEEP:    state_d = ST_CLK_OFF;
            ST_CLK_OFF:  state_d = ST_TEST_OFF;
            ST_TEST_OFF: state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            freq_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                mode_q <= mode_pipe;
                freq_q <= freq_code;
            end
        end
    end

    // outputs
    always_comb begin
        act       = ACT_NONE;
        tmr_start = 1'b0;
        done      = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_CLR_CR:   act = ACT_CLR_CR;
            ST_CLR_RES:  act = ACT_CLR_RES;
            ST_LINK:     act = ACT_LINK;
            ST_PAD_OFF:  act = ACT_PAD_OFF;
            ST_CLKSEL:   act = ACT_CLKSEL;
            ST_LOS:      act = ACT_LOS;
            ST_DEEMPH:   act = ACT_DEEMPH;
            ST_OTG:      act = ACT_OTG;
            ST_TEST_ON:  act = mode_q ? ACT_SS_UP : ACT_HS_UP;
            ST_CLK_ON:   begin act = ACT_CLK_ON; tmr_start = 1'b1; end
            ST_RST_REL:  act = ACT_CLK_REL;
            ST_SLEEP:    act = ACT_SLEEP;
            ST_CLK_OFF:  act = ACT_CLK_OFF;
            ST_TEST_OFF: act = ACT_PWR_OFF;
            ST_DONE:     done = 1'b1;
            default:     act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/usbphy_seq_regs.sv
module usbphy_seq_regs
    import usbphy_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  act_e        act,
    input  logic        mode_q,
    input  logic [2:0]  freq_q,
    output logic [31:0] img_crctl,
    output logic [31:0] img_resume,
    output logic [31:0] img_link,
    output logic [31:0] img_param0,
    output logic [31:0] img_param1,
    output logic [31:0] img_utmi,
    output logic [31:0] img_test,
    output logic [31:0] img_clkrst,
    output logic [31:0] img_clksel
);
    logic [31:0] ck_ref;

    // path-specific reference settings for the clock/reset image
    always_comb begin
        if (mode_q) ck_ref = pll_fields(freq_q);
        else        ck_ref = {24'b0, freq_q, 5'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_crctl  <= '0;
            img_resume <= '0;
            img_link   <= '0;
            img_param0 <= P0_RST_VAL;
            img_param1 <= '0;
            img_utmi   <= '0;
            img_test   <= TEST_RST_VAL;
            img_clkrst <= '0;
            img_clksel <= '0;
        end else begin
            unique case (act)
                ACT_CLR_CR:  img_crctl  <= '0;
                ACT_CLR_RES: img_resume <= '0;
                ACT_LINK:    img_link   <= LINK_INIT;
                ACT_PAD_OFF: img_param0 <= img_param0 & ~P0_PAD_BIT;
                ACT_CLKSEL:  img_clksel <= img_clksel | CLKSEL_BIT;
                ACT_LOS:     img_param0 <= (img_param0 & ~P0_LOS_MASK) | P0_LOS_VAL;
                ACT_DEEMPH:  img_param1 <= (img_param1 & ~P1_DE_MASK) | P1_DE_VAL;
                ACT_OTG:     img_utmi   <= UTMI_RUN;
                ACT_HS_UP:   img_test   <= img_test & ~TEST_HS_PD;
                ACT_SS_UP:   img_test   <= img_test & ~TEST_SS_PD;
                ACT_CLK_ON:  img_clkrst <= (img_clkrst & ~CK_FIELD_MASK) | CK_EXT_REF
                                           | ck_ref | CK_ENABLES | CK_PORT_RST;
                ACT_CLK_REL: img_clkrst <= img_clkrst & ~CK_PORT_RST;
                ACT_SLEEP:   img_utmi   <= UTMI_SLEEP;
                ACT_CLK_OFF: img_clkrst <= img_clkrst & ~CK_OFF_MASK;
                ACT_PWR_OFF: img_test   <= img_test | TEST_HS_PD | TEST_SS_PD;
                default:     img_crctl  <= img_crctl;
            endcase
        end
    end
endmodule

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq
    import usbphy_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ = 250_000_000,
    parameter int unsigned RST_US = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_op,
    input  logic        mode_pipe,
    input  logic [2:0]  freq_code,
    output logic        busy,
    output logic        done,
    output logic        wr_stb,
    output logic [3:0]  wr_sel,
    output logic [31:0] img_crctl,
    output logic [31:0] img_resume,
    output logic [31:0] img_link,
    output logic [31:0] img_param0,
    output logic [31:0] img_param1,
    output logic [31:0] img_utmi,
    output logic [31:0] img_test,
    output logic [31:0] img_clkrst,
    output logic [31:0] img_clksel
);
    localparam int unsigned RST_CYCLES = (CLK_HZ / 1_000_000) * RST_US;
    // wait state lasts RST_CYCLES-1 cycles; release write adds the last one
    localparam int unsigned WAIT_LOAD  = (RST_CYCLES >= 2) ? RST_CYCLES - 2 : 0;

    act_e       act;
    logic       mode_q;
    logic [2:0] freq_q;
    logic       tmr_start;
    logic       tmr_expired;

    usbphy_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .mode_pipe   (mode_pipe),
        .freq_code   (freq_code),
        .tmr_expired (tmr_expired),
        .act         (act),
        .mode_q      (mode_q),
        .freq_q      (freq_q),
        .tmr_start   (tmr_start),
        .busy        (busy),
        .done        (done)
    );

    usbphy_seq_timer #(.LOAD(WAIT_LOAD)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    usbphy_seq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .mode_q     (mode_q),
        .freq_q     (freq_q),
        .img_crctl  (img_crctl),
        .img_resume (img_resume),
        .img_link   (img_link),
        .img_param0 (img_param0),
        .img_param1 (img_param1),
        .img_utmi   (img_utmi),
        .img_test   (img_test),
        .img_clkrst (img_clkrst),
        .img_clksel (img_clksel)
    );

    assign wr_stb = (act != ACT_NONE);
    assign wr_sel = act_target(act);
endmodule

// File: rtl/usbphy_pwr_seq_chk.sv
module usbphy_pwr_seq_chk #(
    parameter int unsigned RST_CYCLES = 2500
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        wr_stb,
    input logic [31:0] img_utmi,
    input logic [31:0] img_test,
    input logic [31:0] img_clkrst
);
    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hi_cnt <= 0;
        else if (img_clkrst[1]) hi_cnt <= hi_cnt + 1;
        else                    hi_cnt <= 0;
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy);

    // R11
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(img_utmi) && $stable(img_test) && $stable(img_clkrst)));

    // R6
    port_rst_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(img_clkrst[1]) |-> (img_clkrst[0] && img_clkrst[4] && img_clkrst[19]
                                  && img_clkrst[20] && img_clkrst[3:2] == 2'b11));

    // R8
    port_rst_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(img_clkrst[1]) |-> (($past(img_clkrst) & ~32'h2) == (img_clkrst & ~32'h2)));

    // R8
    port_rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(img_clkrst[1]) |-> (hi_cnt == RST_CYCLES));
endmodule

bind usbphy_pwr_seq usbphy_pwr_seq_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .wr_stb     (wr_stb),
    .img_utmi   (img_utmi),
    .img_test   (img_test),
    .img_clkrst (img_clkrst)
);

// File: tb/usbphy_pwr_seq_tb_top.sv
module usbphy_pwr_seq_tb_top;
    localparam int RST = 2500;   // 250 MHz x 10 us

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic        mode_pipe = 1'b0;
    logic [2:0]  freq_code = '0;
    logic        busy, done, wr_stb;
    logic [3:0]  wr_sel;
    logic [31:0] img_crctl, img_resume, img_link, img_param0, img_param1;
    logic [31:0] img_utmi, img_test, img_clkrst, img_clksel;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_cr, m_res, m_link, m_p0, m_p1, m_utmi, m_test, m_clk, m_sel;
    logic [3:0]  e_seq [16];
    int          e_len;

    always #2 clk = ~clk;

    usbphy_pwr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .mode_pipe(mode_pipe), .freq_code(freq_code), .busy(busy), .done(done),
        .wr_stb(wr_stb), .wr_sel(wr_sel), .img_crctl(img_crctl),
        .img_resume(img_resume), .img_link(img_link), .img_param0(img_param0),
        .img_param1(img_param1), .img_utmi(img_utmi), .img_test(img_test),
        .img_clkrst(img_clkrst), .img_clksel(img_clksel)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pll(input logic [2:0] c);
        logic [31:0] mul, ssc;
        case (c)
            3'd7: begin mul = 32'h32; ssc = 32'h00; end
            3'd5: begin mul = 32'h68; ssc = 32'h88; end
            3'd4: begin mul = 32'h7D; ssc = 32'h00; end
            3'd3: begin mul = 32'h02; ssc = 32'h88; end
            default: begin mul = 0; ssc = 0; end
        endcase
        return (ssc << 23) | (mul << 11);
    endfunction

    task automatic build_exp(input bit op, input bit md);
        e_len = 0;
        if (op) begin
            e_seq[0] = 5; e_seq[1] = 7; e_seq[2] = 6; e_len = 3;
        end else if (!md) begin
            e_seq[0] = 0; e_seq[1] = 1; e_seq[2] = 2; e_seq[3] = 3; e_seq[4] = 8;
            e_seq[5] = 3; e_seq[6] = 4; e_seq[7] = 5; e_seq[8] = 6; e_seq[9] = 7;
            e_seq[10] = 7; e_len = 11;
        end else begin
            e_seq[0] = 0; e_seq[1] = 1; e_seq[2] = 2; e_seq[3] = 3; e_seq[4] = 8;
            e_seq[5] = 4; e_seq[6] = 6; e_seq[7] = 7; e_seq[8] = 7; e_len = 9;
        end
    endtask

    task automatic model(input bit op, input bit md, input logic [2:0] fq);
        logic [31:0] c;
        if (op) begin
            m_utmi = 32'h43;
            m_clk  = m_clk & ~32'h0018_0001;
            m_test = m_test | 32'hC;
        end else begin
            m_cr = 0; m_res = 0; m_link = 32'h0800_0040;
            m_p0 = m_p0 & ~32'h8000_0000;
            m_sel = m_sel | 32'h4;
            if (!md) m_p0 = (m_p0 & ~(32'h1F << 26)) | (32'h9 << 26);
            m_p1 = (m_p1 & ~32'h1F) | 32'h1C;
            if (!md) m_utmi = 32'h40;
            m_test = m_test & (md ? ~32'h8 : ~32'h4);
            c = (m_clk & ~32'h7F83_F8EC) | 32'hC;
            if (!md) c = c | (32'(fq) << 5);
            else     c = c | exp_pll(fq);
            m_clk = c | 32'h0018_0011;
        end
    endtask

    task automatic cmp_images(input string req);
        chk(req, "img_crctl",  img_crctl,  m_cr);
        chk(req, "img_resume", img_resume, m_res);
        chk(req, "img_link",   img_link,   m_link);
        chk(req, "img_param0", img_param0, m_p0);
        chk(req, "img_param1", img_param1, m_p1);
        chk(req, "img_utmi",   img_utmi,   m_utmi);
        chk(req, "img_test",   img_test,   m_test);
        chk(req, "img_clkrst", img_clkrst, m_clk);
        chk(req, "img_clksel", img_clksel, m_sel);
    endtask

    // poke: cycle at which a foreign request is raised while busy (0 = none)
    task automatic run_seq(input bit op, input bit md, input logic [2:0] fq,
                           input int poke, input string req);
        int cyc = 0;
        int hi = 0;
        int glen = 0;
        int lat;
        logic [3:0]  gseq [16];
        logic [31:0] snap = '0;
        build_exp(op, md);
        lat = op ? 4 : (md ? 9 + RST : 11 + RST);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; mode_pipe = md; freq_code = fq;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                req_valid = 1'b0; mode_pipe = ~md; freq_code = ~fq;   // R2 latched
            end
            if (poke != 0 && cyc == poke) begin req_valid = 1'b1; req_op = ~op; end
            if (poke != 0 && cyc == poke + 1) req_valid = 1'b0;
            if (wr_stb) begin
                if (glen < 16) gseq[glen] = wr_sel;
                glen++;
            end
            if (img_clkrst[1]) begin
                if (hi == 0) snap = img_clkrst;
                hi++;
            end
            if (done) break;
            if (cyc > 3 * RST) begin
                n_chk++; n_fail++;
                $display("FAIL R10 no done actual=%0d expected=%0d", cyc, lat);
                break;
            end
        end
        chk("R10", {req, " done latency"}, cyc, lat);
        chk("R11", {req, " write count"}, glen, e_len);
        for (int i = 0; i < e_len && i < glen; i++)
            chk(op ? "R9" : (md ? "R5" : "R4"), {req, " write order"}, gseq[i], e_seq[i]);
        model(op, md, fq);
        chk("R8", {req, " port reset width"}, hi, op ? 0 : RST);
        if (!op) chk(md ? "R7" : "R6", {req, " clkrst during reset"}, snap, m_clk | 32'h2);
        @(negedge clk);
        chk("R10", {req, " done low after"}, done, 0);
        chk("R10", {req, " idle after"}, busy, 0);
        cmp_images(op ? "R9" : "R3");
        @(negedge clk);
        chk("R2", {req, " no stray write"}, wr_stb, 0);
        chk("R2", {req, " stays idle"}, busy, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit op, md;
        logic [2:0] fq;
        void'($urandom(32'h5EED_1234));
        m_cr = 0; m_res = 0; m_link = 0; m_p0 = 32'h8000_0000; m_p1 = 0;
        m_utmi = 0; m_test = 32'hC; m_clk = 0; m_sel = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "wr_stb", wr_stb, 0);
        cmp_images("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "busy after release", busy, 0);

        run_seq(1'b0, 1'b0, 3'd5, 0, "R3 utmi init");
        run_seq(1'b1, 1'b0, 3'd0, 0, "R9 exit");
        run_seq(1'b0, 1'b1, 3'd7, 0, "R7 pipe code7");
        run_seq(1'b0, 1'b1, 3'd5, 0, "R7 pipe code5");
        run_seq(1'b0, 1'b1, 3'd4, 0, "R7 pipe code4");
        run_seq(1'b0, 1'b1, 3'd3, 0, "R7 pipe code3");
        run_seq(1'b0, 1'b1, 3'd2, 0, "R7 pipe unsupported");
        run_seq(1'b0, 1'b0, 3'd3, 20, "R2 utmi busy poke");
        run_seq(1'b1, 1'b0, 3'd1, 2, "R2 exit busy poke");
        run_seq(1'b0, 1'b0, 3'd7, 5, "R6 utmi code7");
        for (int k = 0; k < 8; k++) begin
            op = 1'($urandom());
            md = 1'($urandom());
            fq = 3'($urandom());
            run_seq(op, md, fq, ($urandom() % 2 == 0) ? 0 : 2 + int'($urandom() % 3), "random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule